// File: doc/BRIEF.md
# Receive Frame Status Queue

This block keeps per-frame receive results for a bit-oriented synchronous receiver. A byte counter follows the current frame: an opening flag clears it and each received byte raises it by one, but only while the receiver runs in the bit-oriented mode. When the frame closes, the count and the live receiver status are stored as one entry in a ten-entry queue. The live status is three residue bits, an overrun bit and a CRC-error bit. Software collects the entries later, one frame at a time.

Software reads the queue in a fixed order. It reads the count-high register first, then optionally the count-low register, then the status register. The count-high read latches whether an entry is waiting and points the status register either at the queued entry or at the live receiver bits. Only the status read that follows a count-high read pops an entry, so repeated status reads cannot drain the queue. A software enable turns the queue on. While the enable is low the queue is held empty and status reads show live bits.

Top module: `frame_status_fifo`

## Requirements
- R1: A flagSeen pulse clears the byte counter to 0. It takes priority over a byteRcvd pulse in the same cycle.
- R2: byteRcvd raises the counter by one only while sdlcMode is 1. The counter stops at 16383 and does not wrap.
- R3: While fifoEnable is 1 and fewer than 10 entries are held, frameEnd stores the counter value together with liveResidue, liveOverrun and liveCrcErr. Entries are read back in arrival order.
- R4: With rdSel=1 (count-high), rdData returns bit 7 = overflow flag, bit 6 = entry available (fifoEnable and queue not empty) and bits 5:0 = count bits 13:8. The count comes from the oldest entry when one is available, and from the live counter otherwise.
- R5: With rdSel=2 (count-low), rdData returns count bits 7:0. The count comes from the oldest entry when the last count-high read saw an entry, and from the live counter otherwise. rdSel=3 reads 0.
- R6: With rdSel=0 (status), rdData returns bits 2:0 residue, bit 3 overrun, bit 4 CRC error and bits 6:5 zero. Bit 7 is 1 when the value comes from a queued entry and 0 when it comes from the live inputs.
- R7: A count-high read that sees an entry steers status to that entry. The next status read returns the entry and removes it.
- R8: A count-high read on an empty queue steers status to the live inputs. The status read that follows removes nothing.
- R9: After one popping status read, further status reads return live status and remove nothing until the next count-high read.
- R10: A frameEnd while 10 entries are held discards the new frame and sets the overflow flag. The flag stays set until fifoEnable goes low or reset is applied.
- R11: While fifoEnable is 0 the queue is empty, the overflow flag is clear, frameEnd stores nothing and status reads return live bits.
- R12: The pointers wrap past the tenth slot, so order and content stay correct over many more than 10 frames.
- R13: After reset, count-high reads 0 and status reads the live bits with bit 7 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sdlcMode | input | 1 | Receiver runs in bit-oriented mode; enables byte counting |
| fifoEnable | input | 1 | Software enable of the status queue |
| flagSeen | input | 1 | Opening flag detected; clears the byte counter |
| byteRcvd | input | 1 | One byte received |
| frameEnd | input | 1 | Frame closed; store count and status |
| liveResidue | input | 3 | Live residue code from the receiver |
| liveOverrun | input | 1 | Live overrun bit |
| liveCrcErr | input | 1 | Live CRC error bit |
| rdStrobe | input | 1 | A register read takes place this cycle |
| rdSel | input | 2 | Register select: 0 status, 1 count-high, 2 count-low |
| rdData | output | 8 | Read data for the selected register (combinational) |

## Verification
The assertions check the cycle-level invariants on every cycle. These are the clear-on-flag and saturation of the counter, the counter holding outside the bit-oriented mode, occupancy staying within ten, no removal from an empty queue, no two removals back to back and the stickiness of the overflow flag. Only the bench scenarios can show that stored counts and status come back in arrival order across pointer wrap. The same holds for the steering chosen by each count-high read, for a full queue discarding the eleventh frame, and for frames closed while disabled leaving nothing behind.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_CNT_HI = 2'd1;
  localparam logic [1:0] SEL_CNT_LO = 2'd2;

  localparam int STAT_W = 5;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fsfStrobes_t;
endpackage

// File: rtl/fsf_ctrl.sv
module fsf_ctrl
  import fsf_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoEnable,
  input  logic        frameEnd,
  input  logic        rdStrobe,
  input  logic [1:0]  rdSel,
  output fsfStrobes_t strobes,
  output logic        useFifo,
  output logic        avail,
  output logic        ovfFlag
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);

  logic [OCC_W-1:0] occ;
  logic isFull, isEmpty, hiRead, stRead;

  assign isFull  = (occ == OCC_FULL);
  assign isEmpty = (occ == '0);
  assign hiRead  = rdStrobe && (rdSel == SEL_CNT_HI);
  assign stRead  = rdStrobe && (rdSel == SEL_STATUS);
  assign avail   = fifoEnable && !isEmpty;

  always_comb begin
    strobes.clear = !fifoEnable;
    strobes.push  = fifoEnable && frameEnd && !isFull;
    strobes.pop   = fifoEnable && stRead && useFifo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ     <= '0;
      useFifo <= 1'b0;
      ovfFlag <= 1'b0;
    end else if (strobes.clear) begin
      occ     <= '0;
      useFifo <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      case ({strobes.push, strobes.pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      if (hiRead)      useFifo <= !isEmpty;
      else if (stRead) useFifo <= 1'b0;
      if (frameEnd && isFull) ovfFlag <= 1'b1;
    end
  end

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_FULL);
  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> !strobes.pop);
  assert_single_pop_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> !strobes.pop);
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEnable && ovfFlag) |=> ovfFlag);
  assert_disable_empties_R11: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEnable |=> (occ == '0) && !ovfFlag);
endmodule

// File: rtl/fsf_datapath.sv
module fsf_datapath
  import fsf_pkg::*;
#(
  parameter int DEPTH   = 10,
  parameter int COUNT_W = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdlcMode,
  input  logic        flagSeen,
  input  logic        byteRcvd,
  input  logic [2:0]  liveResidue,
  input  logic        liveOverrun,
  input  logic        liveCrcErr,
  input  fsfStrobes_t strobes,
  input  logic        useFifo,
  input  logic        avail,
  input  logic        ovfFlag,
  input  logic [1:0]  rdSel,
  output logic [7:0]  rdData
);
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int ENTRY_W = COUNT_W + STAT_W;
  localparam int WIDE_W  = 14;
  localparam logic [COUNT_W-1:0] CNT_MAX  = '1;
  localparam logic [PTR_W-1:0]   PTR_LAST = PTR_W'(DEPTH - 1);

  logic [COUNT_W-1:0] byteCount;
  logic [PTR_W-1:0]   headPtr, tailPtr;
  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [ENTRY_W-1:0] headEntry;
  logic [COUNT_W-1:0] headCount;
  logic [STAT_W-1:0]  headStat, liveStat;
  logic [WIDE_W-1:0]  hiCount, loCount;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   byteCount <= '0;
    else if (flagSeen)                           byteCount <= '0;
    else if (byteRcvd && sdlcMode && byteCount != CNT_MAX) byteCount <= byteCount + 1'b1;
  end

  assign liveStat = {liveCrcErr, liveOverrun, liveResidue};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (strobes.clear) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strobes.push) tailPtr <= nextPtr(tailPtr);
      if (strobes.pop)  headPtr <= nextPtr(headPtr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.push && tailPtr == PTR_W'(i)) slots[i] <= {byteCount, liveStat};
    end
  end

  assign headEntry = slots[headPtr];
  assign headCount = headEntry[ENTRY_W-1:STAT_W];
  assign headStat  = headEntry[STAT_W-1:0];
  assign hiCount   = WIDE_W'(avail   ? headCount : byteCount);
  assign loCount   = WIDE_W'(useFifo ? headCount : byteCount);

  always_comb begin
    case (rdSel)
      SEL_STATUS: rdData = useFifo ? {3'b100, headStat} : {3'b000, liveStat};
      SEL_CNT_HI: rdData = {ovfFlag, avail, hiCount[13:8]};
      SEL_CNT_LO: rdData = loCount[7:0];
      default:    rdData = 8'h00;
    endcase
  end

  assert_flag_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    flagSeen |=> byteCount == '0);
  assert_count_saturates_R2: assert property (@(posedge clk) disable iff (!rstN)
    (byteCount == CNT_MAX && !flagSeen) |=> byteCount == CNT_MAX);
  assert_count_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!sdlcMode && !flagSeen) |=> $stable(byteCount));
  assert_ptr_range_R12: assert property (@(posedge clk) disable iff (!rstN)
    headPtr <= PTR_LAST && tailPtr <= PTR_LAST);
endmodule

// File: rtl/frame_status_fifo.sv
module frame_status_fifo
  import fsf_pkg::*;
#(
  parameter int DEPTH   = 10,
  parameter int COUNT_W = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdlcMode,
  input  logic       fifoEnable,
  input  logic       flagSeen,
  input  logic       byteRcvd,
  input  logic       frameEnd,
  input  logic [2:0] liveResidue,
  input  logic       liveOverrun,
  input  logic       liveCrcErr,
  input  logic       rdStrobe,
  input  logic [1:0] rdSel,
  output logic [7:0] rdData
);
  fsfStrobes_t strobes;
  logic useFifo, avail, ovfFlag;

  fsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rstN, .fifoEnable, .frameEnd, .rdStrobe, .rdSel,
    .strobes, .useFifo, .avail, .ovfFlag
  );

  fsf_datapath #(.DEPTH(DEPTH), .COUNT_W(COUNT_W)) u_dp (
    .clk, .rstN, .sdlcMode, .flagSeen, .byteRcvd,
    .liveResidue, .liveOverrun, .liveCrcErr,
    .strobes, .useFifo, .avail, .ovfFlag, .rdSel, .rdData
  );
endmodule

// File: tb/frame_status_fifo_tb.sv
`timescale 1ns/1ps
module frame_status_fifo_tb;
  logic clk = 0, rstN = 0;
  logic sdlcMode = 0, fifoEnable = 0, flagSeen = 0, byteRcvd = 0, frameEnd = 0;
  logic [2:0] liveResidue = 0;
  logic liveOverrun = 0, liveCrcErr = 0, rdStrobe = 0;
  logic [1:0] rdSel = 0;
  logic [7:0] rdData;

  int checks = 0, failures = 0, liveCount = 0;
  bit ovfExp = 0, done = 0;
  typedef struct { int cnt; int res; int ovr; int crc; } frame_t;
  frame_t expQ[$];

  always #4 clk = ~clk;

  frame_status_fifo u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    rdSel = sel; rdStrobe = 1;
    #1 d = rdData;
    @(negedge clk);
    rdStrobe = 0;
  endtask

  // driver: frame on the receiver side, expected entry into the scoreboard
  task automatic sendFrame(input int n, input int res, input int ovr, input int crc);
    frame_t f;
    @(negedge clk); flagSeen = 1;
    @(negedge clk); flagSeen = 0; byteRcvd = 1;
    repeat (n) @(negedge clk);
    byteRcvd = 0;
    liveResidue = 3'(res); liveOverrun = 1'(ovr); liveCrcErr = 1'(crc);
    frameEnd = 1;
    @(negedge clk); frameEnd = 0;
    liveCount = sdlcMode ? ((n > 16383) ? 16383 : n) : 0;
    f = '{liveCount, res, ovr, crc};
    if (fifoEnable) begin
      if (expQ.size() < 10) expQ.push_back(f);
      else ovfExp = 1;
    end
  endtask

  // monitor: pop expected entry and compare with the read sequence
  task automatic readFrame(input string req);
    logic [7:0] hi, lo, st;
    frame_t f;
    f = expQ.pop_front();
    doRead(2'd1, hi);
    doRead(2'd2, lo);
    doRead(2'd0, st);
    check(hi == {ovfExp, 1'b1, 6'(f.cnt >> 8)}, {req, " R4 count-high"}, hi, {ovfExp, 1'b1, 6'(f.cnt >> 8)});
    check(lo == 8'(f.cnt), {req, " R5 count-low"}, lo, 8'(f.cnt));
    check(st == {3'b100, 1'(f.crc), 1'(f.ovr), 3'(f.res)}, {req, " R6 R7 status"}, st,
          {3'b100, 1'(f.crc), 1'(f.ovr), 3'(f.res)});
  endtask

  function automatic logic [7:0] liveStat();
    return {3'b000, liveCrcErr, liveOverrun, liveResidue};
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R13 reset state
    doRead(2'd1, d); check(d == 8'h00, "R13 count-high after reset", d, 0);
    doRead(2'd0, d); check(d == 8'h00, "R13 status after reset", d, 0);

    fifoEnable = 1; sdlcMode = 1;
    // R3 order and content, several patterns
    sendFrame(5, 3'd5, 0, 1);
    sendFrame(300, 3'd0, 1, 0);
    sendFrame(16, 3'd7, 1, 1);
    readFrame("R3 f0"); readFrame("R3 f1"); readFrame("R3 f2");

    // R8 empty: live steering, no pop
    liveResidue = 3'd2; liveOverrun = 0; liveCrcErr = 1;
    doRead(2'd1, d); check(d == {2'b00, 6'(liveCount >> 8)}, "R8 R4 empty count-high live", d, {2'b00, 6'(liveCount >> 8)});
    doRead(2'd2, d); check(d == 8'(liveCount), "R5 empty count-low live", d, 8'(liveCount));
    doRead(2'd0, d); check(d == liveStat(), "R8 empty status live", d, liveStat());
    doRead(2'd3, d); check(d == 8'h00, "R5 unused select", d, 0);

    // R9 repeated status reads pop at most one
    sendFrame(9, 3'd1, 0, 0);
    sendFrame(10, 3'd6, 0, 1);
    begin
      frame_t f;
      f = expQ.pop_front();
      doRead(2'd1, d); check(d == 8'h40, "R9 count-high first", d, 8'h40);
      doRead(2'd0, d); check(d == {3'b100, 1'(f.crc), 1'(f.ovr), 3'(f.res)}, "R9 first status pops", d, {3'b100, 1'(f.crc), 1'(f.ovr), 3'(f.res)});
      doRead(2'd0, d); check(d == liveStat(), "R9 second status live", d, liveStat());
      doRead(2'd0, d); check(d == liveStat(), "R9 third status live", d, liveStat());
    end
    readFrame("R9 remaining entry");
    doRead(2'd1, d); check(d[6] == 1'b0, "R9 queue empty after two pops", d, 0);

    // R2 no counting outside mode
    sdlcMode = 0;
    sendFrame(7, 3'd3, 0, 0);
    readFrame("R2 mode off count zero");
    sdlcMode = 1;

    // R2 saturation
    sendFrame(16390, 3'd4, 1, 0);
    readFrame("R2 saturate");

    // R1 flag priority over byte in same cycle
    @(negedge clk); byteRcvd = 1;
    repeat (4) @(negedge clk);
    flagSeen = 1;
    @(negedge clk); flagSeen = 0; byteRcvd = 0;
    doRead(2'd1, d); check(d == 8'h00, "R1 count-high after flag", d, 0);
    doRead(2'd2, d); check(d == 8'h00, "R1 count-low after flag", d, 0);

    // R10 overflow, R12 wrap
    for (int i = 0; i < 11; i++) sendFrame(20 + i, i % 8, i % 2, (i / 2) % 2);
    doRead(2'd1, d); check(d[7:6] == 2'b11, "R10 overflow set with entries", d[7:6], 3);
    for (int i = 0; i < 10; i++) readFrame("R10 R12 wrapped entry");
    doRead(2'd1, d); check(d[7:6] == 2'b10, "R10 overflow sticky after drain", d[7:6], 2);

    // R11 disable
    @(negedge clk); fifoEnable = 0;
    ovfExp = 0;
    @(negedge clk);
    doRead(2'd1, d); check(d[7:6] == 2'b00, "R11 overflow cleared", d[7:6], 0);
    sendFrame(3, 3'd5, 1, 1);
    doRead(2'd1, d); check(d[6] == 1'b0, "R11 frame ignored when disabled", d, 0);
    doRead(2'd0, d); check(d == liveStat(), "R11 status live when disabled", d, liveStat());
    fifoEnable = 1;
    doRead(2'd1, d); check(d[7:6] == 2'b00, "R11 nothing stored after re-enable", d[7:6], 0);
    sendFrame(12, 3'd2, 1, 0);
    readFrame("R11 R3 after re-enable");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule